// File: doc/BRIEF.md
# Shared-Memory Request Arbiter with Latency Promotion

This block sits in front of a shared DRAM controller. Three clients compete for it: a graphics engine port, a host processor port and an I/O bus-master port. On each arbitration cycle the block chooses at most one of them and drives a registered one-hot grant. It also sends the winner's address and direction to the controller's command queue as a single-cycle command pulse.

When no override applies, the winner is chosen by a fixed priority: graphics, then host, then I/O. A parameter can swap graphics and host. Each I/O request carries a class bit. An isochronous (downstream) request goes ahead of the fixed order at once. An upstream request has a wait counter. Once the counter reaches a programmable latency ceiling minus a guard margin, the upstream request also goes ahead of the fixed order, so bus-master traffic never waits past its ceiling.

A grant stays with its owner for as long as the owner keeps `req` high, so a multi-beat transfer is never split. No new grant is made while the command queue reports full.

Top module: `mem_req_arbiter`

## Requirements
- R1: After synchronous reset, `gnt` is 3'b000, `cmd_valid` is 0 and the I/O wait counter is zero.
- R2: With no promotion in force, a free arbitration picks the lowest-index ranked requester in the order gfx (`gnt`=3'b001), host (3'b010), io (3'b100). With `HOST_FIRST`=1, host comes before gfx.
- R3: A pending I/O request with `io_iso`=1 (isochronous) wins any free arbitration over gfx and host.
- R4: An upstream I/O request (`io_iso`=0) wins a free arbitration once it has waited at least `LAT_LIMIT-GUARD` cycles without a grant.
- R5: The I/O wait count restarts from zero whenever `io_req` is low or I/O holds or wins the grant.
- R6: While the owner of the grant keeps its `req` high, `gnt` does not change. On the first edge at which the owner's `req` is low, a fresh arbitration runs.
- R7: At most one bit of `gnt` is set in any cycle.
- R8: When `cq_full` is 1 at a free arbitration edge, no grant is issued and `cmd_valid` stays 0. A grant that is already held continues.
- R9: `cmd_valid` is 1 for exactly the cycle after each new grant. In that cycle `cmd_addr` and `cmd_we` carry the winner's address and write flag, and `gnt` names the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gfx_req | input | 1 | Graphics request |
| gfx_addr | input | AW | Graphics address |
| gfx_we | input | 1 | Graphics write flag |
| host_req | input | 1 | Host request |
| host_addr | input | AW | Host address |
| host_we | input | 1 | Host write flag |
| io_req | input | 1 | I/O bus-master request |
| io_addr | input | AW | I/O address |
| io_we | input | 1 | I/O write flag |
| io_iso | input | 1 | 1 = isochronous downstream, 0 = upstream |
| cq_full | input | 1 | Command queue full |
| gnt | output | 3 | One-hot grant: bit0 gfx, bit1 host, bit2 io |
| cmd_valid | output | 1 | New command pulse |
| cmd_addr | output | AW | Forwarded address |
| cmd_we | output | 1 | Forwarded write flag |

## Verification
The bench builds the block with `AW`=16, `LAT_LIMIT`=20 and `GUARD`=4, so the promotion threshold is 16 cycles. With the threshold that low, a directed starvation run can trigger the aging promotion, and a random run can trigger it many times, which the default microsecond-scale ceiling would not allow. `HOST_FIRST` stays at 0, so the bench checks the graphics-first order, including ties in which graphics, host and an aged or isochronous I/O request all compete at once.

// File: rtl/mra_pkg.sv
package mra_pkg;
  localparam int NSRC = 3;
  localparam int SRC_GFX  = 0;
  localparam int SRC_HOST = 1;
  localparam int SRC_IO   = 2;
endpackage

// File: rtl/mra_pick.sv
module mra_pick #(
  parameter bit HOST_FIRST = 1'b0
) (
  input  logic [mra_pkg::NSRC-1:0] req,
  input  logic                     io_urgent,
  output logic [mra_pkg::NSRC-1:0] win
);
  import mra_pkg::*;
  localparam int FIRST  = HOST_FIRST ? SRC_HOST : SRC_GFX;
  localparam int SECOND = HOST_FIRST ? SRC_GFX  : SRC_HOST;

  always_comb begin
    win = '0;
    if (io_urgent && req[SRC_IO]) win[SRC_IO] = 1'b1;
    else if (req[FIRST])          win[FIRST]  = 1'b1;
    else if (req[SECOND])         win[SECOND] = 1'b1;
    else if (req[SRC_IO])         win[SRC_IO] = 1'b1;
  end
endmodule

// File: rtl/mra_age.sv
module mra_age #(
  parameter int PROMO = 16,
  localparam int AGE_W = $clog2(PROMO + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic pending,
  input  logic clear,
  output logic promote
);
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst || !pending || clear) age_q <= '0;
    else if (age_q != AGE_W'(PROMO)) age_q <= age_q + 1'b1;
  end

  assign promote = (age_q == AGE_W'(PROMO));
endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter #(
  parameter int AW         = 32,
  parameter int LAT_LIMIT  = 1000,
  parameter int GUARD      = 50,
  parameter bit HOST_FIRST = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          gfx_req,
  input  logic [AW-1:0] gfx_addr,
  input  logic          gfx_we,
  input  logic          host_req,
  input  logic [AW-1:0] host_addr,
  input  logic          host_we,
  input  logic          io_req,
  input  logic [AW-1:0] io_addr,
  input  logic          io_we,
  input  logic          io_iso,
  input  logic          cq_full,
  output logic [2:0]    gnt,
  output logic          cmd_valid,
  output logic [AW-1:0] cmd_addr,
  output logic          cmd_we
);
  import mra_pkg::*;
  localparam int PROMO = (LAT_LIMIT > GUARD) ? LAT_LIMIT - GUARD : 1;

  logic [NSRC-1:0] req, win, gnt_q, gnt_d;
  logic            owner_busy, arb_go, aged, io_urgent;

  assign req        = {io_req, host_req, gfx_req};
  assign owner_busy = |(gnt_q & req);
  assign arb_go     = !owner_busy && !cq_full;
  assign io_urgent  = io_iso || aged;
  assign gnt_d      = owner_busy ? gnt_q : (arb_go ? win : '0);

  mra_pick #(.HOST_FIRST(HOST_FIRST)) u_pick (
    .req(req), .io_urgent(io_urgent), .win(win)
  );

  mra_age #(.PROMO(PROMO)) u_age (
    .clk(clk), .rst(rst), .pending(io_req),
    .clear(gnt_d[SRC_IO]), .promote(aged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_q     <= '0;
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_we    <= 1'b0;
    end else begin
      gnt_q     <= gnt_d;
      cmd_valid <= arb_go && (|win);
      if (arb_go && (|win)) begin
        unique case (1'b1)
          win[SRC_GFX]:  begin cmd_addr <= gfx_addr;  cmd_we <= gfx_we;  end
          win[SRC_HOST]: begin cmd_addr <= host_addr; cmd_we <= host_we; end
          default:       begin cmd_addr <= io_addr;   cmd_we <= io_we;   end
        endcase
      end
    end
  end

  assign gnt = gnt_q;
endmodule

// File: rtl/mra_checker.sv
module mra_checker #(
  parameter int LAT_LIMIT = 1000,
  parameter int GUARD     = 50
) (
  input logic       clk,
  input logic       rst,
  input logic       gfx_req,
  input logic       host_req,
  input logic       io_req,
  input logic       io_iso,
  input logic       cq_full,
  input logic [2:0] gnt,
  input logic       cmd_valid
);
  localparam int PROMO = (LAT_LIMIT > GUARD) ? LAT_LIMIT - GUARD : 1;
  logic [2:0] reqv;
  logic       free_slot;
  int         wait_cnt;

  assign reqv      = {io_req, host_req, gfx_req};
  assign free_slot = !(|(gnt & reqv));

  always_ff @(posedge clk) begin
    if (rst || !io_req || gnt[2]) wait_cnt <= 0;
    else if (wait_cnt < PROMO) wait_cnt <= wait_cnt + 1;
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (gnt == 3'b000 && !cmd_valid));
  // R2
  gfx_default_chk: assert property (@(posedge clk) disable iff (rst)
    (free_slot && !cq_full && gfx_req && !io_req) |=> (gnt == 3'b001));
  // R3
  iso_promote_chk: assert property (@(posedge clk) disable iff (rst)
    (free_slot && !cq_full && io_req && io_iso) |=> (gnt == 3'b100));
  // R4
  aged_promote_chk: assert property (@(posedge clk) disable iff (rst)
    (free_slot && !cq_full && io_req && wait_cnt >= PROMO) |=> (gnt == 3'b100));
  // R6
  hold_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (!free_slot) |=> $stable(gnt));
  // R7
  onehot_grant_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  // R8
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (free_slot && cq_full) |=> (gnt == 3'b000 && !cmd_valid));
  // R9
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> ($countones(gnt) == 1));
endmodule

bind mem_req_arbiter mra_checker #(.LAT_LIMIT(LAT_LIMIT), .GUARD(GUARD)) u_mra_checker (
  .clk(clk), .rst(rst), .gfx_req(gfx_req), .host_req(host_req),
  .io_req(io_req), .io_iso(io_iso), .cq_full(cq_full),
  .gnt(gnt), .cmd_valid(cmd_valid)
);

// File: tb/mem_req_arbiter_tb.sv
`timescale 1ns/1ps
module mem_req_arbiter_tb;
  localparam int AW = 16, LAT = 20, GRD = 4, PROMO = LAT - GRD;

  logic clk = 1'b0, rst = 1'b1;
  logic gfx_req = 0, gfx_we = 0, host_req = 0, host_we = 0;
  logic io_req = 0, io_we = 0, io_iso = 0, cq_full = 0;
  logic [AW-1:0] gfx_addr = '0, host_addr = '0, io_addr = '0;
  logic [2:0] gnt;
  logic cmd_valid, cmd_we;
  logic [AW-1:0] cmd_addr;

  int checks = 0, failures = 0;
  logic [2:0] m_gnt = '0, e_gnt = '0;
  int m_age = 0;
  logic e_cv = 0, e_we = 0;
  logic [AW-1:0] e_addr = '0;

  always #5 clk = ~clk;

  mem_req_arbiter #(.AW(AW), .LAT_LIMIT(LAT), .GUARD(GRD), .HOST_FIRST(1'b0)) u_dut (
    .clk(clk), .rst(rst),
    .gfx_req(gfx_req), .gfx_addr(gfx_addr), .gfx_we(gfx_we),
    .host_req(host_req), .host_addr(host_addr), .host_we(host_we),
    .io_req(io_req), .io_addr(io_addr), .io_we(io_we), .io_iso(io_iso),
    .cq_full(cq_full), .gnt(gnt), .cmd_valid(cmd_valid),
    .cmd_addr(cmd_addr), .cmd_we(cmd_we)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] ref_pick(input logic [2:0] r, input logic iso, input int age);
    if (r[2] && (iso || age >= PROMO)) return 3'b100;
    if (r[0]) return 3'b001;
    if (r[1]) return 3'b010;
    if (r[2]) return 3'b100;
    return 3'b000;
  endfunction

  // advance one clock, predicting from requirement rules, then compare
  task automatic tick();
    logic [2:0] r, w;
    logic busy, go;
    r = {io_req, host_req, gfx_req};
    busy = |(m_gnt & r);
    go = !busy && !cq_full;
    w = ref_pick(r, io_iso, m_age);
    e_gnt = busy ? m_gnt : (go ? w : 3'b000);
    e_cv = go && (w != 0);
    if (e_cv) begin
      e_addr = w[0] ? gfx_addr : (w[1] ? host_addr : io_addr);
      e_we   = w[0] ? gfx_we   : (w[1] ? host_we   : io_we);
    end
    if (!io_req || e_gnt[2]) m_age = 0;
    else if (m_age < PROMO) m_age++;
    m_gnt = e_gnt;
    @(posedge clk); @(negedge clk);
    check("R2 R3 R4 R6 R8 model gnt", {29'd0, gnt}, {29'd0, e_gnt});
    check("R9 model cmd_valid", {31'd0, cmd_valid}, {31'd0, e_cv});
    if (e_cv) begin
      check("R9 model cmd_addr", {16'd0, cmd_addr}, {16'd0, e_addr});
      check("R9 model cmd_we", {31'd0, cmd_we}, {31'd0, e_we});
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 reset gnt", {29'd0, gnt}, 32'd0);
    check("R1 reset cmd_valid", {31'd0, cmd_valid}, 32'd0);

    // R2 and R9: all request, gfx wins
    gfx_req = 1; gfx_addr = 16'h1111; gfx_we = 1;
    host_req = 1; host_addr = 16'h2222; host_we = 0;
    io_req = 1; io_addr = 16'h3333; io_we = 1; io_iso = 0;
    tick();
    check("R2 gfx first", {29'd0, gnt}, 32'd1);
    check("R9 addr", {16'd0, cmd_addr}, 32'h1111);
    // R6: hold while gfx keeps req
    tick(); tick();
    check("R6 hold", {29'd0, gnt}, 32'd1);
    check("R9 no pulse during hold", {31'd0, cmd_valid}, 32'd0);
    gfx_req = 0; tick();
    check("R6 rearbitrate to host", {29'd0, gnt}, 32'd2);
    // R3: isochronous io beats gfx
    gfx_req = 1; io_iso = 1; host_req = 0; tick();
    check("R3 iso io wins", {29'd0, gnt}, 32'd4);
    io_iso = 0; tick();
    io_req = 0; tick();
    check("R5 io released, gfx wins", {29'd0, gnt}, 32'd1);
    // R4: starve upstream io behind gfx, then free slot with host pending
    io_req = 1; host_req = 1;
    repeat (PROMO + 2) tick();
    gfx_req = 0; tick();
    check("R4 aged io beats host", {29'd0, gnt}, 32'd4);
    // R5: age restarts after grant
    io_req = 0; tick();
    check("R5 host after io", {29'd0, gnt}, 32'd2);
    io_req = 1; repeat (3) tick();
    gfx_req = 1; host_req = 0; tick();
    check("R5 fresh io loses to gfx", {29'd0, gnt}, 32'd1);
    // R8: full queue blocks new grants
    cq_full = 1; gfx_req = 0; tick();
    check("R8 no grant while full", {29'd0, gnt}, 32'd0);
    tick();
    check("R8 no pulse while full", {31'd0, cmd_valid}, 32'd0);
    cq_full = 0; tick();
    check("R7 one grant after full", {31'd0, 1'($countones(gnt) == 1)}, 32'd1);

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      gfx_req  = m_gnt[0] ? ($urandom_range(3) != 0) : ($urandom_range(1) == 1);
      host_req = m_gnt[1] ? ($urandom_range(3) != 0) : ($urandom_range(1) == 1);
      io_req   = m_gnt[2] ? ($urandom_range(3) != 0) : ($urandom_range(4) != 0);
      io_iso   = ($urandom_range(7) == 0);
      cq_full  = ($urandom_range(7) == 0);
      gfx_addr = AW'($urandom); host_addr = AW'($urandom); io_addr = AW'($urandom);
      gfx_we = $urandom_range(1) == 1; host_we = $urandom_range(1) == 1; io_we = $urandom_range(1) == 1;
      tick();
      check("R7 onehot", {31'd0, 1'($countones(gnt) <= 1)}, 32'd1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule